// File: doc/BRIEF.md
# Underrun Interrupt Status Controller

This block collects per-channel FIFO underflow pulses from a three-channel display output engine and turns them into sticky status flags, a single level-sensitive interrupt line and a saturating count of reported underrun events. Software reaches it through a simple single-cycle register port. The port has a control word that carries a global run bit and one interrupt enable per channel. It also has a status word whose flags are cleared by writing ones.

A flag records an underflow whether or not its channel's interrupt is enabled. The enable only decides whether that flag drives the interrupt line and whether it is counted. Software therefore enables a channel, services the interrupt, and clears the flag with a write of one to its status bit. Clearing and enabling are separate actions.

Top module: `underrun_irq_ctrl`

## Requirements
- R1: After reset, the control word, all status flags, `irq` and `event_count` are zero.
- R2: The control word is at address 0. Bit 0 is the run bit, shown on `engine_run`. Bits 1, 2 and 3 are the interrupt enables of channels 0, 1 and 2. A write to address 0 replaces it, and a read returns it with the upper bits zero.
- R3: While the run bit is set, a high `uflow[i]` at a clock edge sets the status flag of channel i from the next cycle on, whether or not that channel is enabled. The flags read back in bits 2:0 of address 1.
- R4: While the run bit is clear, `uflow` pulses have no effect on the flags.
- R5: A write to address 1 clears every flag whose data bit is one and leaves the flags whose data bit is zero unchanged. One write can clear all three flags.
- R6: When an accepted underflow pulse and a clearing write hit the same flag in the same cycle, the flag stays set.
- R7: `irq` is high exactly when at least one channel has both its flag and its enable set. It follows the registered state with no added delay.
- R8: `event_count` rises by the number of channels whose enabled flag (flag AND enable) went from 0 to 1. It shows the new value one cycle after the flag or enable changes, and it holds at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uflow | input | NUM_CH | Per-channel underflow pulse from the output FIFOs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 status |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 status |
| rd_data | output | DATA_W | Read data, combinational |
| engine_run | output | 1 | Global run bit of the control word |
| irq | output | 1 | Level interrupt |
| event_count | output | CNT_W | Saturating underrun event counter |

## Verification
A flag that is lost or stuck shows in the status read and on `irq` the cycle after the pulse or clear. A wrong edge register in the counter shows one cycle later as an `event_count` that is off by the number of missed or doubled rises. The bench sweeps every enable pattern against every pulse pattern with the run bit set, so any bit swap between enables, flags and channels shows up as a mismatch on `irq` or `event_count` within two cycles. Pulse and clear collisions and counter saturation are driven on purpose, because a wrong priority or a wrap is otherwise invisible.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  localparam int   CTRL_RUN_BIT = 0;
  localparam int   CTRL_IEN_LSB = 1;
endpackage

// File: rtl/uirq_regs.sv
module uirq_regs
  import uirq_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  input  logic [NUM_CH-1:0] flags,
  output logic [DATA_W-1:0] rd_data,
  output logic              run,
  output logic [NUM_CH-1:0] ien,
  output logic [NUM_CH-1:0] clr
);
  localparam int CTRL_W = NUM_CH + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_wr;
  logic              stat_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign stat_wr = wr_en && (wr_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  assign run = ctrl_q[CTRL_RUN_BIT];
  assign ien = ctrl_q[CTRL_IEN_LSB +: NUM_CH];
  assign clr = stat_wr ? wr_data[NUM_CH-1:0] : '0;

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_CTRL) rd_data[CTRL_W-1:0] = ctrl_q;
    else                      rd_data[NUM_CH-1:0] = flags;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q)) else $error("AST_CTRL_HOLD"); // R2
endmodule

// File: rtl/uirq_flag.sv
module uirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  input  logic run,
  input  logic clr,
  output logic flag
);
  logic accept;
  assign accept = pulse && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (accept) flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end

  AST_PULSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> flag) else $error("AST_PULSE_WINS"); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !accept) |=> !flag) else $error("AST_W1C_CLEARS"); // R5
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(pulse && run)) else $error("AST_FLAG_SOURCE"); // R4
endmodule

// File: rtl/uirq_event_cnt.sv
module uirq_event_cnt #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] en_flags,
  output logic [CNT_W-1:0]  count
);
  localparam int INC_W = $clog2(NUM_CH + 1);

  function automatic logic [INC_W-1:0] rise_total(input logic [NUM_CH-1:0] r);
    logic [INC_W-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_CH; i++) s = s + INC_W'(r[i]);
    return s;
  endfunction

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] c,
                                               input logic [INC_W-1:0] inc);
    logic [CNT_W:0] s;
    s = {1'b0, c} + (CNT_W + 1)'(inc);
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] rises;

  assign rises = en_flags & ~en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      count <= '0;
    end else begin
      en_q  <= en_flags;
      count <= sat_add(count, rise_total(rises));
    end
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '1) |=> (count == '1)) else $error("AST_CNT_SATURATE"); // R8
  AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count >= $past(count))) else $error("AST_CNT_NO_DROP"); // R8
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rises == '0) |=> $stable(count)) else $error("AST_CNT_IDLE"); // R8
endmodule

// File: rtl/underrun_irq_ctrl.sv
module underrun_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] uflow,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              engine_run,
  output logic              irq,
  output logic [CNT_W-1:0]  event_count
);
  logic [NUM_CH-1:0] flags;
  logic [NUM_CH-1:0] ien;
  logic [NUM_CH-1:0] clr;
  logic [NUM_CH-1:0] en_flags;

  uirq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .flags(flags),
    .rd_data(rd_data), .run(engine_run), .ien(ien), .clr(clr)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    uirq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .pulse(uflow[g]), .run(engine_run),
      .clr(clr[g]), .flag(flags[g])
    );
  end

  assign en_flags = flags & ien;
  assign irq      = |en_flags;

  uirq_event_cnt #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_flags(en_flags), .count(event_count)
  );

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq) else $error("AST_IRQ_NEEDS_ENABLE"); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq) else $error("AST_IRQ_NEEDS_FLAG"); // R7
endmodule

// File: tb/sim_underrun_irq_ctrl.sv
module sim_underrun_irq_ctrl;
  localparam int NCH = 3;
  localparam int DW  = 8;
  localparam int CW  = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] uflow = '0;
  logic           wr_en = 1'b0;
  logic           wr_addr = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic           rd_addr = 1'b0;
  logic [DW-1:0]  rd_data;
  logic           engine_run;
  logic           irq;
  logic [CW-1:0]  event_count;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [NCH-1:0] m_flag = '0;
  logic [NCH-1:0] m_ien  = '0;
  logic           m_run  = 1'b0;
  logic [NCH-1:0] m_ef   = '0;
  int             m_cnt  = 0;

  always #5 clk = ~clk;

  underrun_irq_ctrl #(.NUM_CH(NCH), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .uflow(uflow), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .engine_run(engine_run), .irq(irq),
    .event_count(event_count)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_update();
    logic [NCH-1:0] ef;
    ef = m_flag & m_ien;
    for (int i = 0; i < NCH; i++)
      if (ef[i] && !m_ef[i]) m_cnt = (m_cnt >= 255) ? 255 : m_cnt + 1;
    m_ef = ef;
  endtask

  // one operation: optional pulse and optional write in the same cycle
  task automatic op(input logic [NCH-1:0] p, input logic we,
                    input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    uflow = p; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    uflow = '0; wr_en = 1'b0;
    @(negedge clk);
    // model: pulse wins over clear; control write replaces control
    if (we && a == 1'b1) m_flag = m_flag & ~d[NCH-1:0];
    if (m_run) m_flag = m_flag | p;
    if (we && a == 1'b0) begin
      m_run = d[0];
      m_ien = d[NCH:1];
    end
    model_update();
  endtask

  task automatic read_stat(output int v);
    rd_addr = 1'b1; #1; v = int'(rd_data);
  endtask

  task automatic read_ctrl(output int v);
    rd_addr = 1'b0; #1; v = int'(rd_data);
  endtask

  task automatic check_all(input string tag);
    int v;
    read_stat(v);
    check({tag, " R3 status"}, v, int'(m_flag));
    check({tag, " R7 irq"}, int'(irq), int'(|(m_flag & m_ien)));
    check({tag, " R8 count"}, int'(event_count), m_cnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    read_ctrl(v);  check("R1 ctrl", v, 0);
    read_stat(v);  check("R1 status", v, 0);
    check("R1 irq", int'(irq), 0);
    check("R1 count", int'(event_count), 0);

    // R4 pulses ignored while run clear (enables set, run clear)
    op('0, 1'b1, 1'b0, 8'b0000_1110);
    op(3'b111, 1'b0, 1'b0, '0);
    read_stat(v);  check("R4 status ignored", v, 0);
    check("R4 irq", int'(irq), 0);
    check("R4 count", int'(event_count), 0);

    // R2 control layout and readback
    op('0, 1'b1, 1'b0, 8'b1111_0101);
    read_ctrl(v);  check("R2 ctrl readback", v, 5);
    check("R2 engine_run", int'(engine_run), 1);

    // R3/R7/R8 sweep: every enable pattern against every pulse pattern
    for (int e = 0; e < 8; e++) begin
      for (int m = 0; m < 8; m++) begin
        op('0, 1'b1, 1'b1, 8'h07);                 // R5 clear all in one write
        read_stat(v); check("R5 clear all", v, 0);
        op('0, 1'b1, 1'b0, 8'((e << 1) | 1));
        op(3'(m), 1'b0, 1'b0, '0);
        check_all("sweep");
      end
    end

    // R5 partial clear and zero write
    op('0, 1'b1, 1'b0, 8'h01);                     // run, no enables
    op(3'b111, 1'b0, 1'b0, '0);
    op('0, 1'b1, 1'b1, 8'h00);
    read_stat(v); check("R5 zero write keeps", v, 7);
    op('0, 1'b1, 1'b1, 8'h02);
    read_stat(v); check("R5 partial clear", v, 5);
    check_all("R5 after");

    // R8 enabling a set flag counts a rise
    op('0, 1'b1, 1'b0, 8'h0B);                     // enable ch0, ch2
    check_all("R8 late enable");
    check("R7 late enable irq", int'(irq), 1);

    // R6 pulse and clear together on ch1, clear only on ch0
    op(3'b010, 1'b1, 1'b1, 8'h03);
    read_stat(v); check("R6 collision", v, 6);
    check_all("R6 after");

    // R8 saturation
    op('0, 1'b1, 1'b0, 8'h0F);
    for (int k = 0; k < 100; k++) begin
      op('0, 1'b1, 1'b1, 8'h07);
      op(3'b111, 1'b0, 1'b0, '0);
    end
    check("R8 saturated", int'(event_count), 255);
    check_all("R8 sat model");
    op('0, 1'b1, 1'b1, 8'h07);
    op(3'b111, 1'b0, 1'b0, '0);
    check("R8 holds at max", int'(event_count), 255);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule